// File: doc/BRIEF.md
# Receive Descriptor Scatter Engine

This block takes one received frame at a time and spreads it across a ring of 8-byte receive descriptors in system memory. A frame is announced with its payload length and a precomputed 32-bit check value. The payload then arrives one byte per handshake. The engine reads each descriptor and fills that descriptor's buffer with as many bytes as the programmed buffer size allows. It then writes the descriptor back, cleared of its empty mark and carrying the byte count. The four check bytes follow the payload in the byte stream, and a chunk boundary may fall anywhere inside them.

Each descriptor is two little-endian 32-bit words. The first word holds a 16-bit length in bits 15:0 and a 16-bit flag set in bits 31:16. The second word holds the buffer address. Within the flag set, bit 15 marks the descriptor empty (owned by the engine), bit 13 wraps the ring, bit 11 marks the last buffer of a frame, bit 5 reports an over-length frame and bit 0 reports truncation. After each frame, and on request, the engine reads the descriptor it now points to and uses that descriptor's empty mark to decide whether it can take another frame.

Memory is reached through a single word port. A read returns its data on the cycle after the request. Writes to buffers use one byte lane at a time.

Top module: `rx_scatter`

## Requirements
- R1: The stored frame is the payload followed by the 32-bit check value, most significant byte first. The stored size is the payload length plus 4.
- R2: When payload length plus 4 exceeds the hard maximum MAX_FRM, the stored size is clipped to MAX_FRM and the last 4 stored bytes are still the check value. Payload bytes past the clip point are accepted and discarded. The last descriptor gets both the truncation flag (bit 0) and the over-length flag (bit 5).
- R3: When the stored size exceeds len_limit_i, the last descriptor gets the over-length flag (bit 5) and nothing is truncated.
- R4: Each descriptor takes min(remaining stored bytes, buffer size) bytes, written from its buffer address upward. The byte count goes into word-0 bits 15:0.
- R5: When a descriptor read for the frame has its empty flag clear, that descriptor is left untouched and the remainder of the frame is consumed and dropped. No frame event is raised, and receive becomes disabled.
- R6: Every filled descriptor is written back with the empty flag cleared and its other flag bits kept. The final one also gets the last flag (bit 11) plus any error flags and pulses evt_rxf_o. Each earlier one pulses evt_rxb_o.
- R7: After each write-back the descriptor pointer advances by 8. When the descriptor's wrap flag (bit 13) is set, the pointer instead reloads from the ring base.
- R8: After a frame, rx_en_o takes the empty flag of the descriptor now pointed to.
- R9: A demand pulse re-reads the current descriptor's empty flag into rx_en_o only when ctl_en_i is high and rx_en_o is low. ctl_en_i low forces rx_en_o low from the next cycle.
- R10: The buffer size keeps only bits 10:4 of a write. A value of zero acts as 16. The reset value is 0x600.
- R11: A frame offered while rx_en_o is low is fully consumed with no memory access and no event.
- R12: In reset, and right after it, start_ready_o is 1, while rx_en_o, mem_req_o and both events are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_en_i | input | 1 | Controller enable |
| rx_demand_i | input | 1 | Pulse: re-check the current descriptor |
| ring_load_i | input | 1 | Pulse: load the ring base and reset the pointer (taken while idle) |
| ring_base_i | input | AW | Ring base byte address (bits 1:0 ignored) |
| bsz_wr_i | input | 1 | Pulse: write the buffer size |
| bsz_wdata_i | input | 16 | Buffer size write value |
| len_limit_i | input | 16 | Programmable over-length threshold |
| frm_start_i | input | 1 | Frame announce |
| frm_len_i | input | LW | Payload length in bytes |
| frm_crc_i | input | 32 | Check value to append |
| start_ready_o | output | 1 | Engine idle, announce accepted |
| byte_valid_i | input | 1 | Payload byte valid |
| byte_data_i | input | 8 | Payload byte |
| byte_ready_o | output | 1 | Payload byte accepted |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_be_o | output | 4 | Byte lane enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after a read request |
| evt_rxb_o | output | 1 | Non-final buffer written back |
| evt_rxf_o | output | 1 | Final buffer of a frame written back |
| rx_en_o | output | 1 | Receive enabled |

## Verification
A wrong pointer or a stale wrap decision shows up on the very next descriptor read as a wrong address. It then shows up in memory as a buffer filled in the wrong place, visible as soon as that frame completes. A miscounted position or payload counter puts check bytes at the wrong offset or leaves the byte stream hung. The bench catches the first case by comparing the whole descriptor and buffer region after every frame, and the watchdog catches the second. A wrong enable decision is visible on rx_en_o within three cycles of the frame end or the demand pulse. It also shows on the next frame as descriptors that are touched or left untouched when they should not be.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int unsigned FL_EMPTY  = 15;
  localparam int unsigned FL_WRAP   = 13;
  localparam int unsigned FL_LAST   = 11;
  localparam int unsigned FL_LONG   = 5;
  localparam int unsigned FL_TRUNC  = 0;
  localparam int unsigned CRC_BYTES = 4;
  localparam int unsigned DESC_STEP = 8;
  localparam int unsigned BSZ_W     = 11;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD0,
    S_RD1,
    S_DCHK,
    S_XFER,
    S_WB,
    S_DRAIN,
    S_CHK0,
    S_CHK1
  } rxs_state_e;
endpackage

// File: rtl/rxs_len_calc.sv
module rxs_len_calc
  import rxs_pkg::*;
#(
  parameter int unsigned LW      = 16,
  parameter int unsigned MAX_FRM = 2048
) (
  input  logic [LW-1:0] len_i,
  input  logic [15:0]   limit_i,
  output logic [LW:0]   size_o,
  output logic [LW:0]   keep_o,
  output logic          trunc_o,
  output logic          long_o
);
  localparam logic [LW:0] CRC_W = (LW+1)'(CRC_BYTES);
  localparam logic [LW:0] MAX_W = (LW+1)'(MAX_FRM);

  logic [LW:0] raw;

  always_comb begin
    raw     = {1'b0, len_i} + CRC_W;
    trunc_o = raw > MAX_W;
    size_o  = trunc_o ? MAX_W : raw;
    long_o  = trunc_o | (size_o > (LW+1)'(limit_i));
    keep_o  = size_o - CRC_W;
  end
endmodule

// File: rtl/rxs_ring_ptr.sv
module rxs_ring_ptr
  import rxs_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_wr_i,
  input  logic [AW-1:0]    base_i,
  input  logic             bsz_wr_i,
  input  logic [15:0]      bsz_wdata_i,
  input  logic             adv_i,
  input  logic             wrap_i,
  output logic [AW-1:0]    ptr_o,
  output logic [BSZ_W-1:0] bsz_o
);
  logic [AW-1:0] base_q, ptr_q;
  logic [6:0]    bsz_q;
  logic          unused_bits;

  assign unused_bits = ^{bsz_wdata_i[15:11], bsz_wdata_i[3:0], base_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ptr_q  <= '0;
      bsz_q  <= 7'h60;
    end else begin
      if (base_wr_i) begin
        base_q <= {base_i[AW-1:2], 2'b00};
        ptr_q  <= {base_i[AW-1:2], 2'b00};
      end else if (adv_i) begin
        ptr_q <= wrap_i ? base_q : ptr_q + AW'(DESC_STEP);
      end
      if (bsz_wr_i) bsz_q <= bsz_wdata_i[10:4];
    end
  end

  assign ptr_o = ptr_q;
  assign bsz_o = (bsz_q == '0) ? BSZ_W'(16) : {bsz_q, 4'b0000};

  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wrap_i && !base_wr_i) |=> (ptr_o == $past(ptr_o) + AW'(DESC_STEP)));
  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && wrap_i && !base_wr_i) |=> (ptr_o == base_q));
endmodule

// File: rtl/rxs_byte_sel.sv
module rxs_byte_sel #(
  parameter int unsigned SW = 17
) (
  input  logic [SW-1:0] pos_i,
  input  logic [SW-1:0] keep_i,
  input  logic [31:0]   crc_i,
  input  logic [7:0]    pay_i,
  output logic          is_crc_o,
  output logic [7:0]    byte_o
);
  logic [1:0] idx;

  assign is_crc_o = pos_i >= keep_i;
  assign idx      = 2'(pos_i - keep_i);

  always_comb begin
    if (!is_crc_o) begin
      byte_o = pay_i;
    end else begin
      unique case (idx)
        2'd0:    byte_o = crc_i[31:24];
        2'd1:    byte_o = crc_i[23:16];
        2'd2:    byte_o = crc_i[15:8];
        default: byte_o = crc_i[7:0];
      endcase
    end
  end
endmodule

// File: rtl/rx_scatter.sv
module rx_scatter
  import rxs_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned LW      = 16,
  parameter int unsigned MAX_FRM = 2048
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_en_i,
  input  logic          rx_demand_i,
  input  logic          ring_load_i,
  input  logic [AW-1:0] ring_base_i,
  input  logic          bsz_wr_i,
  input  logic [15:0]   bsz_wdata_i,
  input  logic [15:0]   len_limit_i,
  input  logic          frm_start_i,
  input  logic [LW-1:0] frm_len_i,
  input  logic [31:0]   frm_crc_i,
  output logic          start_ready_o,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_data_i,
  output logic          byte_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [3:0]    mem_be_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          evt_rxb_o,
  output logic          evt_rxf_o,
  output logic          rx_en_o
);
  localparam int unsigned SW = LW + 1;

  rxs_state_e       state_q;
  logic [SW-1:0]    size_q, keep_q, pos_q, off_q, chunk_q;
  logic [LW-1:0]    pay_left_q;
  logic [31:0]      crc_q;
  logic [15:0]      flags_q;
  logic [AW-1:0]    dbuf_q;
  logic             trunc_q, long_q, drop_all_q, rx_en_q;

  logic [SW-1:0]    size_c, keep_c, rem_c, chunk_c, bsz_ext;
  logic             trunc_c, long_c, is_crc, avail, last, base_wr, adv;
  logic [7:0]       wr_byte;
  logic [AW-1:0]    ptr, baddr;
  logic [BSZ_W-1:0] bsz;
  logic [15:0]      flags_new;

  rxs_len_calc #(.LW(LW), .MAX_FRM(MAX_FRM)) u_len (
    .len_i   (frm_len_i),
    .limit_i (len_limit_i),
    .size_o  (size_c),
    .keep_o  (keep_c),
    .trunc_o (trunc_c),
    .long_o  (long_c)
  );

  assign base_wr = ring_load_i && (state_q == S_IDLE);
  assign adv     = (state_q == S_WB);

  rxs_ring_ptr #(.AW(AW)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_wr_i   (base_wr),
    .base_i      (ring_base_i),
    .bsz_wr_i    (bsz_wr_i),
    .bsz_wdata_i (bsz_wdata_i),
    .adv_i       (adv),
    .wrap_i      (flags_q[FL_WRAP]),
    .ptr_o       (ptr),
    .bsz_o       (bsz)
  );

  rxs_byte_sel #(.SW(SW)) u_sel (
    .pos_i    (pos_q),
    .keep_i   (keep_q),
    .crc_i    (crc_q),
    .pay_i    (byte_data_i),
    .is_crc_o (is_crc),
    .byte_o   (wr_byte)
  );

  assign rem_c   = size_q - pos_q;
  assign bsz_ext = SW'(bsz);
  assign chunk_c = (rem_c < bsz_ext) ? rem_c : bsz_ext;
  assign avail   = is_crc || byte_valid_i;
  assign last    = (pos_q == size_q);
  assign baddr   = dbuf_q + AW'(off_q);

  always_comb begin
    flags_new = flags_q;
    flags_new[FL_EMPTY] = 1'b0;
    if (last) begin
      flags_new[FL_LAST] = 1'b1;
      if (trunc_q) flags_new[FL_TRUNC] = 1'b1;
      if (long_q)  flags_new[FL_LONG]  = 1'b1;
    end
  end

  // Memory port: one request per cycle, reads return next cycle
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr;
    mem_be_o    = 4'h0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_RD0, S_CHK0: mem_req_o = 1'b1;
      S_RD1: begin
        mem_req_o  = mem_rdata_i[16 + FL_EMPTY];
        mem_addr_o = ptr + AW'(4);
      end
      S_XFER: begin
        mem_req_o   = avail;
        mem_we_o    = 1'b1;
        mem_addr_o  = {baddr[AW-1:2], 2'b00};
        mem_be_o    = 4'b0001 << baddr[1:0];
        mem_wdata_o = {4{wr_byte}};
      end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = 4'hf;
        mem_wdata_o = {flags_new, 16'(chunk_q)};
      end
      default: ;
    endcase
  end

  assign start_ready_o = (state_q == S_IDLE);
  assign byte_ready_o  = ((state_q == S_XFER) && !is_crc) || (state_q == S_DRAIN);
  assign evt_rxf_o     = (state_q == S_WB) && last;
  assign evt_rxb_o     = (state_q == S_WB) && !last;
  assign rx_en_o       = rx_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      size_q     <= '0;
      keep_q     <= '0;
      pos_q      <= '0;
      off_q      <= '0;
      chunk_q    <= '0;
      pay_left_q <= '0;
      crc_q      <= '0;
      flags_q    <= '0;
      dbuf_q     <= '0;
      trunc_q    <= 1'b0;
      long_q     <= 1'b0;
      drop_all_q <= 1'b0;
      rx_en_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (frm_start_i) begin
            size_q     <= size_c;
            keep_q     <= keep_c;
            trunc_q    <= trunc_c;
            long_q     <= long_c;
            crc_q      <= frm_crc_i;
            pay_left_q <= frm_len_i;
            pos_q      <= '0;
            if (rx_en_q) begin
              state_q <= S_RD0;
            end else begin
              drop_all_q <= 1'b1;
              state_q    <= S_DRAIN;
            end
          end else if (rx_demand_i && ctl_en_i && !rx_en_q) begin
            state_q <= S_CHK0;
          end
        end
        S_RD0: state_q <= S_RD1;
        S_RD1: begin
          flags_q <= mem_rdata_i[31:16];
          state_q <= mem_rdata_i[16 + FL_EMPTY] ? S_DCHK : S_DRAIN;
        end
        S_DCHK: begin
          dbuf_q  <= mem_rdata_i[AW-1:0];
          chunk_q <= chunk_c;
          off_q   <= '0;
          state_q <= S_XFER;
        end
        S_XFER: begin
          if (avail) begin
            pos_q <= pos_q + SW'(1);
            off_q <= off_q + SW'(1);
            if (!is_crc) pay_left_q <= pay_left_q - LW'(1);
            if (off_q + SW'(1) == chunk_q) state_q <= S_WB;
          end
        end
        S_WB: begin
          if (last) state_q <= (pay_left_q != '0) ? S_DRAIN : S_CHK0;
          else      state_q <= S_RD0;
        end
        S_DRAIN: begin
          if (pay_left_q == '0) begin
            state_q    <= drop_all_q ? S_IDLE : S_CHK0;
            drop_all_q <= 1'b0;
          end else if (byte_valid_i) begin
            pay_left_q <= pay_left_q - LW'(1);
          end
        end
        S_CHK0: state_q <= S_CHK1;
        S_CHK1: begin
          rx_en_q <= mem_rdata_i[16 + FL_EMPTY];
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
      if (!ctl_en_i) rx_en_q <= 1'b0;
    end
  end

  a_r6_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_rxb_o && evt_rxf_o));
  a_r11_drop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_all_q |-> (!mem_req_o && !evt_rxb_o && !evt_rxf_o));
  a_r9_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_en_i |=> !rx_en_o);
  a_r4_chunk_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_XFER) |-> (chunk_q != '0 && chunk_q <= bsz_ext));
  a_r5_stop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD1 && !mem_rdata_i[16 + FL_EMPTY]) |=> (state_q == S_DRAIN && !mem_req_o));
endmodule

// File: tb/sim_rx_scatter.sv
`timescale 1ns/1ps
module sim_rx_scatter;
  localparam int AW = 16;
  localparam int LW = 16;
  localparam int MAXF = 128;
  localparam int RING = 32'h100;
  localparam int BUFB = 32'h400;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ctl_en = 0, demand = 0, ring_load = 0, bsz_wr = 0, frm_start = 0, byte_valid = 0;
  logic [AW-1:0] ring_base = '0;
  logic [15:0] bsz_wdata = '0, len_limit = '0;
  logic [LW-1:0] frm_len = '0;
  logic [31:0] frm_crc = '0, rdata = '0;
  logic [7:0] byte_data = '0;
  logic start_ready, byte_ready, mem_req, mem_we, evt_rxb, evt_rxf, rx_en;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;

  logic hw_we = 0;
  int hw_addr = 0;
  logic [7:0] hw_byte = '0;
  logic [7:0] mem [0:4095];
  logic [7:0] exp_m [0:4095];
  logic [7:0] pay [0:255];

  int checks = 0, errors = 0;
  int cnt_rxb = 0, cnt_rxf = 0;
  int mptr, mbase, mbs, erxb, erxf;
  bit mrxen, mctl;

  always #2.5 clk = ~clk;

  rx_scatter #(.AW(AW), .LW(LW), .MAX_FRM(MAXF)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ctl_en_i(ctl_en), .rx_demand_i(demand),
    .ring_load_i(ring_load), .ring_base_i(ring_base), .bsz_wr_i(bsz_wr),
    .bsz_wdata_i(bsz_wdata), .len_limit_i(len_limit), .frm_start_i(frm_start),
    .frm_len_i(frm_len), .frm_crc_i(frm_crc), .start_ready_o(start_ready),
    .byte_valid_i(byte_valid), .byte_data_i(byte_data), .byte_ready_o(byte_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(rdata), .evt_rxb_o(evt_rxb),
    .evt_rxf_o(evt_rxf), .rx_en_o(rx_en)
  );

  always @(posedge clk) begin
    if (hw_we) mem[hw_addr] <= hw_byte;
    else if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[int'(mem_addr[11:0]) + b] <= mem_wdata[8*b +: 8];
      end else begin
        rdata <= {mem[int'(mem_addr[11:0]) + 3], mem[int'(mem_addr[11:0]) + 2],
                  mem[int'(mem_addr[11:0]) + 1], mem[int'(mem_addr[11:0])]};
      end
    end
  end

  always @(posedge clk) if (rst_ni) begin
    if (evt_rxb) cnt_rxb <= cnt_rxb + 1;
    if (evt_rxf) cnt_rxf <= cnt_rxf + 1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog (R1..R12 run) actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string msg, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", msg, act, expv);
    end
  endtask

  function automatic logic [31:0] ew(input int a);
    return {exp_m[a+3], exp_m[a+2], exp_m[a+1], exp_m[a]};
  endfunction

  task automatic hwrite(input int a, input logic [7:0] d);
    @(negedge clk); hw_we = 1; hw_addr = a; hw_byte = d; exp_m[a] = d;
    @(negedge clk); hw_we = 0;
  endtask

  task automatic hword(input int a, input logic [31:0] w);
    for (int b = 0; b < 4; b++) hwrite(a + b, w[8*b +: 8]);
  endtask

  task automatic arm_all();
    for (int i = 0; i < 8; i++) hword(RING + 8*i, {(i == 7) ? 16'hA000 : 16'h8000, 16'h0});
  endtask

  task automatic set_bsz(input logic [15:0] v);
    @(negedge clk); bsz_wr = 1; bsz_wdata = v;
    @(negedge clk); bsz_wr = 0;
    mbs = ((v & 16'h07F0) == 0) ? 16 : int'(v & 16'h07F0);
  endtask

  task automatic set_ctl(input bit v);
    @(negedge clk); ctl_en = v; mctl = v;
    if (!v) mrxen = 0;
    @(negedge clk);
  endtask

  task automatic kick();
    @(negedge clk); demand = 1;
    @(negedge clk); demand = 0;
    if (mctl && !mrxen) mrxen = ew(mptr)[31];
    repeat (3) @(negedge clk);
  endtask

  task automatic model_frame(input int len, input logic [31:0] crc, input int lim);
    int size, keep, pos, ch, bufa;
    bit tr, lg;
    logic [31:0] w0;
    logic [15:0] fl;
    erxb = 0; erxf = 0;
    size = len + 4; tr = 0; lg = 0;
    if (size > MAXF) begin size = MAXF; tr = 1; lg = 1; end
    if (size > lim) lg = 1;
    keep = size - 4;
    if (!mrxen) return;
    pos = 0;
    while (pos < size) begin
      w0 = ew(mptr);
      if (!w0[31]) break;
      bufa = int'(ew(mptr + 4) & 32'hFFFF);
      ch = (size - pos < mbs) ? size - pos : mbs;
      for (int k = 0; k < ch; k++)
        exp_m[bufa + k] = (pos + k < keep) ? pay[pos + k] : 8'(crc >> (24 - 8*(pos + k - keep)));
      pos += ch;
      fl = w0[31:16] & 16'h7FFF;
      if (pos == size) begin
        fl = fl | 16'h0800 | (tr ? 16'h0001 : 16'h0) | (lg ? 16'h0020 : 16'h0);
        erxf++;
      end else erxb++;
      {exp_m[mptr+3], exp_m[mptr+2], exp_m[mptr+1], exp_m[mptr]} = {fl, 16'(ch)};
      mptr = fl[13] ? mbase : mptr + 8;
    end
    mrxen = ew(mptr)[31];
  endtask

  task automatic send_frame(input int len, input int lim, input string tag);
    int b0, f0, idx, mis;
    logic [31:0] crc;
    crc = $urandom;
    for (int i = 0; i < 256; i++) pay[i] = 8'($urandom);
    model_frame(len, crc, lim);
    b0 = cnt_rxb; f0 = cnt_rxf;
    @(negedge clk); frm_start = 1; frm_len = LW'(len); frm_crc = crc; len_limit = 16'(lim);
    @(negedge clk); frm_start = 0;
    idx = 0;
    while (idx < len) begin
      byte_valid = ($urandom % 4) != 0;
      byte_data = pay[idx];
      #1;
      if (byte_valid && byte_ready) idx++;
      @(negedge clk);
    end
    byte_valid = 0;
    while (!start_ready) @(negedge clk);
    mis = -1;
    for (int a = RING; a < 32'hC00; a++) if (mis < 0 && mem[a] !== exp_m[a]) mis = a;
    chk(mis < 0, {tag, " memory image"}, (mis < 0) ? 0 : int'(mem[mis]), (mis < 0) ? 0 : int'(exp_m[mis]));
    chk(rx_en === mrxen, {tag, " R8 rx_en after frame"}, int'(rx_en), int'(mrxen));
    chk(cnt_rxb - b0 == erxb, {tag, " R6 buffer events"}, cnt_rxb - b0, erxb);
    chk(cnt_rxf - f0 == erxf, {tag, " R6 frame events"}, cnt_rxf - f0, erxf);
  endtask

  initial begin
    int nidx;
    void'($urandom(32'h5EED_0042));
    for (int a = 0; a < 4096; a++) begin mem[a] = 8'h00; exp_m[a] = 8'h00; end
    mptr = 0; mbase = 0; mbs = 32'h600; mrxen = 0; mctl = 0;
    repeat (4) @(negedge clk);
    chk(start_ready === 1'b1 && rx_en === 1'b0 && mem_req === 1'b0, "R12 in reset",
        int'({start_ready, rx_en, mem_req}), 3'b100);
    rst_ni = 1;
    @(negedge clk);
    chk(start_ready === 1'b1 && rx_en === 1'b0, "R12 after reset ready/en", int'({start_ready, rx_en}), 2'b10);
    chk(mem_req === 1'b0 && evt_rxb === 1'b0 && evt_rxf === 1'b0, "R12 after reset quiet",
        int'({mem_req, evt_rxb, evt_rxf}), 0);

    for (int i = 0; i < 8; i++) hword(RING + 8*i + 4, BUFB + 32'h100*i);
    arm_all();
    @(negedge clk); ring_load = 1; ring_base = AW'(RING);
    @(negedge clk); ring_load = 0; mptr = RING; mbase = RING;
    set_bsz(16'h003F);

    // R11: frame while receive is off
    send_frame(30, 1000, "R11 drop while off");
    set_ctl(1);
    kick();
    chk(rx_en === 1'b1, "R9 demand enables", int'(rx_en), 1);

    send_frame(100, 1000, "R1 R4 R10 split 48/48/8");
    arm_all(); kick();
    set_bsz(16'h000F);
    send_frame(14, 1000, "R1 R4 R10 zero size, crc straddle");
    arm_all(); kick();
    send_frame(0, 1000, "R1 empty payload");
    arm_all(); kick();
    set_bsz(16'h0030);
    send_frame(140, 2000, "R2 truncation");
    arm_all(); kick();
    send_frame(60, 50, "R3 over limit");
    arm_all(); kick();
    set_bsz(16'h0010);
    send_frame(120, 2000, "R7 R8 full ring wrap");
    chk(rx_en === 1'b0, "R8 ring exhausted disables", int'(rx_en), 0);

    // R5: descriptor after the current one is not empty
    arm_all(); kick();
    nidx = ((mptr - RING) / 8 + 1) % 8;
    hwrite(RING + 8*nidx + 3, (nidx == 7) ? 8'h20 : 8'h00);
    send_frame(40, 2000, "R5 stop at busy descriptor");
    chk(rx_en === 1'b0, "R5 receive disabled after stop", int'(rx_en), 0);

    // R9: ctl disable and gated demand
    arm_all(); kick();
    chk(rx_en === 1'b1, "R9 demand re-enables", int'(rx_en), 1);
    set_ctl(0);
    chk(rx_en === 1'b0, "R9 ctl low clears", int'(rx_en), 0);
    kick();
    chk(rx_en === 1'b0, "R9 demand ignored while ctl low", int'(rx_en), 0);
    set_ctl(1);
    kick();
    chk(rx_en === 1'b1, "R9 demand with ctl high", int'(rx_en), 1);

    for (int it = 0; it < 30; it++) begin
      arm_all(); kick();
      set_bsz(16'($urandom));
      send_frame($urandom % 150, 20 + $urandom % 200, "R1 R2 R3 R4 R6 R7 random");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule